// File: doc/BRIEF.md
# Three-Port Parallel I/O Interface

This block gives a processor three 8-bit parallel ports (A, B, C) and one control register, all reached through an 8-bit register interface. The interface has a chip select, read and write strobes, and a 2-bit register select. The ports fall into two groups, and each group has its own mode. The first group is port A plus the upper nibble of port C. The second group is port B plus the lower nibble of port C.

A group can act as plain I/O. It can also act as a handshaked port that uses reserved port C pins for a strobe or acknowledge input and a buffer flag output. Port A alone can also work as a bidirectional handshaked bus.

One control word reconfigures both groups at once. A second kind of control word sets or clears a single port C latch bit without touching the other seven. Pad drivers are outside the block. Every port exposes its output value and an output enable.

Top module: `tri_port_pio`

## Requirements
- R1: While rst is high and after it, every pin is an input in plain mode. pa_oe, pb_oe and pc_oe are 0, all output latches are 0, and rdata is 0.
- R2: A write to select 2'b11 with bit 7 = 1 is a configuration word. Its fields are:
  - bits 6:5: first-group mode (00 plain, 01 handshaked, 1x bidirectional)
  - bit 4: port A direction
  - bit 3: upper port C direction
  - bit 2: second-group mode (0 plain, 1 handshaked)
  - bit 1: port B direction
  - bit 0: lower port C direction
  
  A direction bit of 1 means input. The new enables show in the cycle after the write.
- R3: A configuration word sets the A, B and C output latches to 0. It also clears both input-full flags and sets both output-full-n flags to 1.
- R4: A write to select 2'b11 with bit 7 = 0 writes bit 0 into the port C latch bit numbered by bits 3:1. No other C bit changes, and no A or B latch changes.
- R5: A read pulse on select 00 (A), 01 (B) or 10 (C) loads rdata in the cycle after the pulse. Each input pin returns its sampled pin value, and each output returns its latch. rdata holds its value when no read occurs. A read of select 11 returns 0.
- R6: A write to select 00, 01 or 10 loads that port's output latch. Output pins show the new value in the next cycle.
- R7: In handshaked input, the first cycle in which the strobe pin is sampled low latches the port pins and raises the input-full flag. For port A the strobe is C4 and the flag is C5; for port B they are C2 and C1. A read of that port returns the latched byte and clears the flag. If a strobe falls in the same cycle as a read, the flag stays set.
- R8: In handshaked output, a write to the port drops the output-full-n flag (port A: C7, port B: C1). A falling edge on the acknowledge pin (port A: C6, port B: C2) raises that flag again.
- R9: In bidirectional mode, port A has both handshakes at once (C4/C5 for input, C6/C7 for output). pa_oe is 1 only in the cycle after C6 is sampled low. Mode values 10 and 11 behave alike.
- R10: Port C pins that no handshake claims follow the direction bit of their nibble; C3 belongs to the lower nibble. A handshake input pin is never driven, and a handshake flag pin is always driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | Register select: 00 A, 01 B, 10 C, 11 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C drive values |
| pc_oe | output | 8 | Port C per-pin output enables |

## Verification
Two situations are the hardest to create from the pins. The first is a strobe edge that lands in the same cycle as the processor read that would clear the input-full flag. The bench sets up that collision by driving the strobe low and issuing the read in one common cycle. It then checks that the flag survives and that the read returned the older byte. The second is the bidirectional mode, where the enable of port A depends on when the acknowledge pin is sampled. The bench toggles the acknowledge pin one cycle at a time. A behavioural model follows every clock and catches any shift in the enable window.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PW = 8;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  // configuration held from a mode word, bit-aligned with wdata[6:0]
  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                 b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  // port C pin roles in handshake modes
  localparam int PC_A_STB  = 4;
  localparam int PC_A_FULL = 5;
  localparam int PC_A_ACK  = 6;
  localparam int PC_A_OBF  = 7;
  localparam int PC_B_HSI  = 2;
  localparam int PC_B_FLAG = 1;
endpackage

// File: rtl/pio_ctl.sv
module pio_ctl
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic          pc_wr,
  input  logic [PW-1:0] wdata,
  output cfg_t          cfg,
  output logic [PW-1:0] pc_lat,
  output logic          mode_set
);
  localparam int BW = $clog2(PW);

  assign mode_set = ctl_wr & wdata[PW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= CFG_RESET;
      pc_lat <= '0;
    end else if (mode_set) begin
      cfg    <= cfg_t'(wdata[PW-2:0]);
      pc_lat <= '0;
    end else if (ctl_wr) begin
      pc_lat[wdata[BW:1]] <= wdata[0];
    end else if (pc_wr) begin
      pc_lat <= wdata;
    end
  end
endmodule

// File: rtl/pio_hsport.sv
module pio_hsport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic         in_hs,
  input  logic         out_hs,
  input  logic         stb_n,
  input  logic         ack_n,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins,
  output logic [W-1:0] out_lat,
  output logic [W-1:0] in_lat,
  output logic         ibf,
  output logic         obf_n
);
  logic stb_q, ack_q;
  logic stb_fall, ack_fall;

  assign stb_fall = stb_q & ~stb_n;
  assign ack_fall = ack_q & ~ack_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q   <= 1'b1;
      ack_q   <= 1'b1;
      out_lat <= '0;
      in_lat  <= '0;
      ibf     <= 1'b0;
      obf_n   <= 1'b1;
    end else begin
      stb_q <= stb_n;
      ack_q <= ack_n;
      if (clr) begin
        out_lat <= '0;
        ibf     <= 1'b0;
        obf_n   <= 1'b1;
      end else begin
        if (wr_en) begin
          out_lat <= wdata;
          if (out_hs) obf_n <= 1'b0;
        end else if (ack_fall && out_hs) begin
          obf_n <= 1'b1;
        end
        if (stb_fall && in_hs) begin
          in_lat <= pins;
          ibf    <= 1'b1;
        end else if (rd_en && in_hs) begin
          ibf <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic          pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic          pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  localparam int HN = PW / 2;

  cfg_t          cfg;
  logic [PW-1:0] pc_lat, in_a, in_b;
  logic          mode_set;
  logic          rd_hit, wr_hit;
  logic          a_m2, a_in_hs, a_out_hs, b_in_hs, b_out_hs;
  logic          ibf_a, obf_n_a, ibf_b, obf_n_b;
  logic          a_ack_q;
  logic [PW-1:0] rd_mux;

  assign rd_hit = cs & rd;
  assign wr_hit = cs & wr;

  always_comb begin
    a_m2     = cfg.a_mode[1];
    a_in_hs  = a_m2 | (cfg.a_mode == 2'b01 &&  cfg.a_in);
    a_out_hs = a_m2 | (cfg.a_mode == 2'b01 && !cfg.a_in);
    b_in_hs  = cfg.b_mode &  cfg.b_in;
    b_out_hs = cfg.b_mode & ~cfg.b_in;
  end

  pio_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (wr_hit && addr == SEL_CTL),
    .pc_wr    (wr_hit && addr == SEL_C),
    .wdata    (wdata),
    .cfg      (cfg),
    .pc_lat   (pc_lat),
    .mode_set (mode_set)
  );

  pio_hsport #(.W(PW)) u_port_a (
    .clk     (clk),
    .rst     (rst),
    .clr     (mode_set),
    .wr_en   (wr_hit && addr == SEL_A),
    .rd_en   (rd_hit && addr == SEL_A),
    .in_hs   (a_in_hs),
    .out_hs  (a_out_hs),
    .stb_n   (pc_in[PC_A_STB]),
    .ack_n   (pc_in[PC_A_ACK]),
    .wdata   (wdata),
    .pins    (pa_in),
    .out_lat (pa_out),
    .in_lat  (in_a),
    .ibf     (ibf_a),
    .obf_n   (obf_n_a)
  );

  pio_hsport #(.W(PW)) u_port_b (
    .clk     (clk),
    .rst     (rst),
    .clr     (mode_set),
    .wr_en   (wr_hit && addr == SEL_B),
    .rd_en   (rd_hit && addr == SEL_B),
    .in_hs   (b_in_hs),
    .out_hs  (b_out_hs),
    .stb_n   (pc_in[PC_B_HSI]),
    .ack_n   (pc_in[PC_B_HSI]),
    .wdata   (wdata),
    .pins    (pb_in),
    .out_lat (pb_out),
    .in_lat  (in_b),
    .ibf     (ibf_b),
    .obf_n   (obf_n_b)
  );

  // sampled acknowledge gates the bidirectional driver
  always_ff @(posedge clk) begin
    if (rst) a_ack_q <= 1'b1;
    else     a_ack_q <= pc_in[PC_A_ACK];
  end

  assign pa_oe = a_m2 ? ~a_ack_q : ~cfg.a_in;
  assign pb_oe = ~cfg.b_in;

  // port C: nibble directions, overridden by handshake pin roles
  always_comb begin
    pc_oe  = {{HN{~cfg.cu_in}}, {HN{~cfg.cl_in}}};
    pc_out = pc_lat;
    if (a_in_hs) begin
      pc_oe[PC_A_STB]   = 1'b0;
      pc_oe[PC_A_FULL]  = 1'b1;
      pc_out[PC_A_FULL] = ibf_a;
    end
    if (a_out_hs) begin
      pc_oe[PC_A_ACK]  = 1'b0;
      pc_oe[PC_A_OBF]  = 1'b1;
      pc_out[PC_A_OBF] = obf_n_a;
    end
    if (cfg.b_mode) begin
      pc_oe[PC_B_HSI]   = 1'b0;
      pc_oe[PC_B_FLAG]  = 1'b1;
      pc_out[PC_B_FLAG] = cfg.b_in ? ibf_b : obf_n_b;
    end
  end

  always_comb begin
    unique case (sel_e'(addr))
      SEL_A:   rd_mux = a_in_hs ? in_a : (cfg.a_in ? pa_in : pa_out);
      SEL_B:   rd_mux = b_in_hs ? in_b : (cfg.b_in ? pb_in : pb_out);
      SEL_C:   rd_mux = (pc_oe & pc_out) | (~pc_oe & pc_in);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= rd_mux;
  end
endmodule

// File: rtl/pio_chk.sv
module pio_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       rd,
  input logic       wr,
  input logic [1:0] addr,
  input logic       w7,
  input logic [7:0] rdata,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic       pa_oe,
  input logic       stb_a,
  input logic       ack_a,
  input logic       full_a,
  input logic       a_m2,
  input logic       a_in_hs
);
  // R3
  a_r3_modeset_clears: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'b11 && w7) |=> (pa_out == 8'h00 && pb_out == 8'h00));

  // R4
  a_r4_bitword_keeps_ab: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'b11 && !w7) |=> ($stable(pa_out) && $stable(pb_out)));

  // R5
  a_r5_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |=> $stable(rdata));

  // R7
  a_r7_read_clears_full: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == 2'b00 && a_in_hs && stb_a) |=> !full_a);

  // R9
  a_r9_bidir_idle_ack: assert property (@(posedge clk) disable iff (rst)
    (a_m2 && ack_a) |=> (!a_m2 || !pa_oe));
endmodule

bind tri_port_pio pio_chk u_pio_chk (
  .clk     (clk),
  .rst     (rst),
  .cs      (cs),
  .rd      (rd),
  .wr      (wr),
  .addr    (addr),
  .w7      (wdata[7]),
  .rdata   (rdata),
  .pa_out  (pa_out),
  .pb_out  (pb_out),
  .pa_oe   (pa_oe),
  .stb_a   (pc_in[4]),
  .ack_a   (pc_in[6]),
  .full_a  (pc_out[5]),
  .a_m2    (a_m2),
  .a_in_hs (a_in_hs)
);

// File: tb/test_tri_port_pio.sv
module test_tri_port_pio;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1, cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00, pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] rdata, pa_out, pb_out, pc_out, pc_oe;
  logic       pa_oe, pb_oe;

  tri_port_pio i_tri_port_pio (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  int    total = 0, bad = 0;
  string cur_req = "R1";
  bit    live = 0, done = 0;

  // ---------------- behavioural reference model ----------------
  int       m_amode;
  bit       m_ain, m_cuin, m_bmode, m_bin, m_clin;
  bit       m_ibfa, m_obfa, m_ibfb, m_obfb, m_p4, m_p6, m_p2;
  bit [7:0] m_la, m_lb, m_lc, m_ia, m_ib, m_rd;

  function automatic bit ai(); return m_amode >= 2 || (m_amode == 1 && m_ain);  endfunction
  function automatic bit ao(); return m_amode >= 2 || (m_amode == 1 && !m_ain); endfunction
  function automatic bit bi(); return m_bmode && m_bin;  endfunction
  function automatic bit bo(); return m_bmode && !m_bin; endfunction

  function automatic bit [7:0] m_coe();
    bit [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = (i >= 4) ? !m_cuin : !m_clin;
    if (ai()) begin v[4] = 0; v[5] = 1; end
    if (ao()) begin v[6] = 0; v[7] = 1; end
    if (m_bmode) begin v[2] = 0; v[1] = 1; end
    return v;
  endfunction

  function automatic bit [7:0] m_cout();
    bit [7:0] v = m_lc;
    if (ai()) v[5] = m_ibfa;
    if (ao()) v[7] = m_obfa;
    if (m_bmode) v[1] = m_bin ? m_ibfb : m_obfb;
    return v;
  endfunction

  task automatic m_reset();
    m_amode = 0; m_ain = 1; m_cuin = 1; m_bmode = 0; m_bin = 1; m_clin = 1;
    m_la = 0; m_lb = 0; m_lc = 0; m_ia = 0; m_ib = 0; m_rd = 0;
    m_ibfa = 0; m_ibfb = 0; m_obfa = 1; m_obfb = 1;
    m_p4 = 1; m_p6 = 1; m_p2 = 1;
  endtask

  always @(posedge clk) begin
    if (rst) m_reset();
    else begin
      bit fa, fk, fb, xai, xao, xbi, xbo;
      bit [7:0] rv;
      xai = ai(); xao = ao(); xbi = bi(); xbo = bo();
      fa = m_p4 && !pc_in[4]; fk = m_p6 && !pc_in[6]; fb = m_p2 && !pc_in[2];
      case (addr)
        2'd0: rv = xai ? m_ia : (m_ain ? pa_in : m_la);
        2'd1: rv = xbi ? m_ib : (m_bin ? pb_in : m_lb);
        2'd2: rv = (m_coe() & m_cout()) | (~m_coe() & pc_in);
        default: rv = 0;
      endcase
      if (cs && rd) m_rd = rv;
      if (cs && wr && addr == 0) begin m_la = wdata; if (xao) m_obfa = 0; end
      else if (fk && xao) m_obfa = 1;
      if (fa && xai) begin m_ia = pa_in; m_ibfa = 1; end
      else if (cs && rd && addr == 0 && xai) m_ibfa = 0;
      if (cs && wr && addr == 1) begin m_lb = wdata; if (xbo) m_obfb = 0; end
      else if (fb && xbo) m_obfb = 1;
      if (fb && xbi) begin m_ib = pb_in; m_ibfb = 1; end
      else if (cs && rd && addr == 1 && xbi) m_ibfb = 0;
      if (cs && wr && addr == 2) m_lc = wdata;
      if (cs && wr && addr == 3) begin
        if (wdata[7]) begin
          m_amode = int'(wdata[6:5]); m_ain = wdata[4]; m_cuin = wdata[3];
          m_bmode = wdata[2]; m_bin = wdata[1]; m_clin = wdata[0];
          m_la = 0; m_lb = 0; m_lc = 0;
          m_ibfa = 0; m_ibfb = 0; m_obfa = 1; m_obfb = 1;
        end else m_lc[wdata[3:1]] = wdata[0];
      end
      m_p4 = pc_in[4]; m_p6 = pc_in[6]; m_p2 = pc_in[2];
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      bit [7:0] e_pa_oe;
      e_pa_oe = {7'd0, (m_amode >= 2) ? !m_p6 : !m_ain};
      total++;
      if (pa_out !== m_la || pb_out !== m_lb || pc_out !== m_cout() ||
          pc_oe !== m_coe() || {7'd0, pa_oe} !== e_pa_oe ||
          pb_oe !== !m_bin || rdata !== m_rd) begin
        bad++;
        $display("FAIL %s model: act pa=%h/%b pb=%h/%b pc=%h/%h rd=%h exp pa=%h/%b pb=%h/%b pc=%h/%h rd=%h",
                 cur_req, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe, rdata,
                 m_la, e_pa_oe[0], m_lb, !m_bin, m_cout(), m_coe(), m_rd);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    cs = 1; wr = 1; addr = a; wdata = d;
    tick();
    cs = 0; wr = 0;
  endtask

  task automatic cpu_rd(logic [1:0] a);
    cs = 1; rd = 1; addr = a;
    tick();
    cs = 0; rd = 0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    rst = 0; live = 1;
    // R1 reset state
    chk("R1", {7'd0, pa_oe}, 8'h00);
    chk("R1", {7'd0, pb_oe}, 8'h00);
    chk("R1", pc_oe, 8'h00);
    chk("R1", pa_out, 8'h00);
    chk("R1", rdata, 8'h00);

    // R2 / R6: everything plain output
    cur_req = "R2";
    cpu_wr(2'd3, 8'h80);
    chk("R2", {6'd0, pa_oe, pb_oe}, 8'h03);
    chk("R2", pc_oe, 8'hFF);
    cur_req = "R6";
    cpu_wr(2'd0, 8'h5A); cpu_wr(2'd1, 8'hC3); cpu_wr(2'd2, 8'h96);
    chk("R6", pa_out, 8'h5A);
    chk("R6", pb_out, 8'hC3);
    chk("R6", pc_out, 8'h96);
    cur_req = "R5";
    cpu_rd(2'd0); chk("R5", rdata, 8'h5A);
    cpu_rd(2'd2); chk("R5", rdata, 8'h96);
    tick(); chk("R5", rdata, 8'h96);

    // R3: mode word back to all inputs clears latches
    cur_req = "R3";
    cpu_wr(2'd3, 8'h9B);
    chk("R3", pa_out, 8'h00);
    chk("R3", pb_out, 8'h00);
    chk("R3", pc_out, 8'h00);
    cur_req = "R5";
    pa_in = 8'h12; pb_in = 8'h34; pc_in = 8'hA5;
    cpu_rd(2'd0); chk("R5", rdata, 8'h12);
    cpu_rd(2'd1); chk("R5", rdata, 8'h34);
    cpu_rd(2'd2); chk("R5", rdata, 8'hA5);
    cpu_rd(2'd3); chk("R5", rdata, 8'h00);
    pc_in = 8'hFF;

    // R10 / R4: mixed nibbles and single-bit words
    cur_req = "R10";
    cpu_wr(2'd3, 8'h88);
    chk("R10", pc_oe, 8'h0F);
    cur_req = "R4";
    cpu_wr(2'd0, 8'h3E);
    cpu_wr(2'd3, 8'h07); chk("R4", pc_out, 8'h08);
    cpu_wr(2'd3, 8'h0F); chk("R4", pc_out, 8'h88);
    cpu_rd(2'd2);        chk("R4", rdata, 8'hF8);
    cpu_wr(2'd3, 8'h06); chk("R4", pc_out, 8'h80);
    chk("R4", pa_out, 8'h3E);

    // R7: handshaked input on port A
    cur_req = "R7";
    cpu_wr(2'd3, 8'hB0);
    chk("R10", pc_oe, 8'hEF);
    chk("R7", {7'd0, pc_out[5]}, 8'h00);
    pa_in = 8'h3C; pc_in[4] = 0; tick();
    chk("R7", {7'd0, pc_out[5]}, 8'h01);
    pa_in = 8'h77; pc_in[4] = 1; tick();
    cpu_rd(2'd0);
    chk("R7", rdata, 8'h3C);
    chk("R7", {7'd0, pc_out[5]}, 8'h00);
    // strobe falls in the same cycle as a read: flag stays set
    pa_in = 8'h55; pc_in[4] = 0; cpu_rd(2'd0);
    chk("R7", rdata, 8'h3C);
    chk("R7", {7'd0, pc_out[5]}, 8'h01);
    pc_in[4] = 1; cpu_rd(2'd0);
    chk("R7", rdata, 8'h55);

    // R8: handshaked output on port A
    cur_req = "R8";
    cpu_wr(2'd3, 8'hA0);
    chk("R8", {7'd0, pa_oe}, 8'h01);
    chk("R8", {7'd0, pc_out[7]}, 8'h01);
    cpu_wr(2'd0, 8'h81);
    chk("R8", pa_out, 8'h81);
    chk("R8", {7'd0, pc_out[7]}, 8'h00);
    pc_in[6] = 0; tick();
    chk("R8", {7'd0, pc_out[7]}, 8'h01);
    pc_in[6] = 1; tick();

    // R9: bidirectional port A
    cur_req = "R9";
    cpu_wr(2'd3, 8'hC0);
    chk("R9", {7'd0, pa_oe}, 8'h00);
    pc_in[6] = 0; tick();
    chk("R9", {7'd0, pa_oe}, 8'h01);
    pc_in[6] = 1; tick();
    chk("R9", {7'd0, pa_oe}, 8'h00);
    cpu_wr(2'd0, 8'hE7);
    chk("R9", {7'd0, pc_out[7]}, 8'h00);
    pa_in = 8'h19; pc_in[4] = 0; tick();
    chk("R9", {7'd0, pc_out[5]}, 8'h01);
    pc_in[4] = 1; cpu_rd(2'd0);
    chk("R9", rdata, 8'h19);
    cpu_wr(2'd3, 8'hE0);
    chk("R9", {7'd0, pa_oe, pc_oe[4], pc_oe[6]}, 8'h00);

    // second group handshakes (R7 / R8 on port B)
    cur_req = "R7";
    cpu_wr(2'd3, 8'h86);
    chk("R10", {6'd0, pc_oe[2], pc_oe[1]}, 8'h01);
    pb_in = 8'h4D; pc_in[2] = 0; tick();
    chk("R7", {7'd0, pc_out[1]}, 8'h01);
    pc_in[2] = 1; cpu_rd(2'd1);
    chk("R7", rdata, 8'h4D);
    chk("R7", {7'd0, pc_out[1]}, 8'h00);
    cur_req = "R8";
    cpu_wr(2'd3, 8'h84);
    chk("R8", {6'd0, pb_oe, pc_out[1]}, 8'h03);
    cpu_wr(2'd1, 8'hAA);
    chk("R8", pb_out, 8'hAA);
    chk("R8", {7'd0, pc_out[1]}, 8'h00);
    pc_in[2] = 0; tick();
    chk("R8", {7'd0, pc_out[1]}, 8'h01);
    pc_in[2] = 1; tick(); tick();

    done = 1;
    summary();
    $finish;
  end
endmodule